// File: doc/BRIEF.md
# Instruction Trace Event Qualifier

This block sits on the per-cycle instruction trace port of a processor core. Each cycle it receives an 18-bit control word, the address of the executed instruction, and three trace-control inputs: a trace enable, a debug-state indication and a prohibited-region indication. It applies the layered qualification among the control flags, so that a flag counts only when the flag it depends on is set. It turns the result into a registered event strobe with decoded fields. When a branch phantom executes, it computes the phantom's address from the instruction address and the instruction size of the current state.

The block also tracks exceptions across trace on/off transitions. It stays silent about exceptions until the first instruction has been traced after trace becomes active. An exception that is taken is held until the next executed instruction, which is the first instruction at the vector, and is reported together with that instruction. If trace is shut off automatically by debug state or a prohibited region while an exception is still held, the block pulses a lost-exception flag. Reserved exception type codes and contradictory state bits raise error pulses.

Top module: `itrace_qual`

Trace is active when `trace_en` is high and neither `dbg_halt` nor `prohib_region` is high.

Control word fields:
- bit 0: master valid.
- bit 1: instruction executed.
- bit 2: phantom executed.
- bit 3: Thumb state.
- bit 4: bytecode state.
- bit 5: instruction condition fail.
- bit 6: phantom condition fail.
- bit 7: indirect branch.
- bit 8: context-ID update.
- bit 9: data instruction.
- bit 10: bounce.
- bit 11: exception.
- bits 14:12: exception type.
- bit 15: exception cancelled the previous instruction.
- bit 16: data abort.
- bit 17: kill outstanding slots.

## Requirements
- R1: Every output is registered with one cycle of latency. When bit 0 is low, or trace is not active, no event field is high in the following cycle and `bp_addr` is 0.
- R2: `ev_valid`, `ev_inst`, `ev_phantom`, `ev_thumb` and `ev_bcode` follow bits 0, 1, 2, 3 and 4 respectively. Bits 1 to 4 count only while bit 0 is high.
- R3: The following outputs count only while the instruction flag (bits 0 and 1) is set: `ev_inst_ccfail` (bit 5), `ev_indirect` (bit 7), `ev_ctxid` (bit 8) and `ev_data` (bit 9). `ev_phan_ccfail` (bit 6) counts only while the phantom flag (bits 0 and 2) is set.
- R4: `ev_bounce` (bit 10) counts only when `ev_data` would be set in the same cycle.
- R5: The exception fields count only when the exception bit (bit 11) and bit 0 are both high: kill (bit 17), data abort (bit 16), cancel (bit 15) and type (bits 14:12). The type is reported unchanged on `ev_exc_kind`, with 001 for IRQ, 101 for FIQ, 100 for a bytecode-state exception, 110 for a precise data abort and 000 for any other exception.
- R6: An active exception whose type is 010, 011 or 111 pulses `err_exc_code` in the following cycle.
- R7: `bp_addr` equals the instruction address minus the instruction size when a phantom is qualified, and is 0 otherwise. The size is 1 when only bit 4 is set, 2 when only bit 3 is set, and 4 otherwise.
- R8: A qualified cycle with both bit 3 and bit 4 set pulses `err_mode` in the following cycle.
- R9: An exception seen while trace is active and started is held until the next qualified instruction. That instruction's event carries `ev_exc` high with the held fields. If a newer exception arrives before the instruction, it replaces the held one. An exception in the same cycle as the instruction is reported with it directly.
- R10: After trace becomes active (and after reset), no exception is reported on or before the first qualified instruction. An exception seen before that instruction is discarded.
- R11: If an exception is held when `dbg_halt` or `prohib_region` rises, `exc_lost` pulses in the following cycle and the held exception is dropped. Dropping `trace_en` alone discards the held exception without a pulse.
- R12: A synchronous active-low reset clears every output, the held exception and the trace-started state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_in | input | 18 | Per-cycle trace control word |
| iaddr | input | AW | Address of the executed instruction |
| trace_en | input | 1 | Trace enabled |
| dbg_halt | input | 1 | Core in debug state (automatic shutoff) |
| prohib_region | input | 1 | Core in prohibited trace region (automatic shutoff) |
| ev_valid | output | 1 | Qualified cycle strobe |
| ev_inst | output | 1 | Instruction executed |
| ev_phantom | output | 1 | Branch phantom executed |
| ev_thumb | output | 1 | Thumb state |
| ev_bcode | output | 1 | Bytecode state |
| ev_inst_ccfail | output | 1 | Instruction failed condition |
| ev_phan_ccfail | output | 1 | Phantom failed condition |
| ev_indirect | output | 1 | Indirect branch |
| ev_ctxid | output | 1 | Context-ID update |
| ev_data | output | 1 | Data instruction |
| ev_bounce | output | 1 | Data slot killed (bounce) |
| bp_addr | output | AW | Branch phantom address |
| ev_exc | output | 1 | Exception reported with this instruction |
| ev_exc_kind | output | 3 | Reported exception type |
| ev_exc_kill | output | 1 | Reported kill-outstanding-slots |
| ev_exc_dabt | output | 1 | Reported data abort |
| ev_exc_cancel | output | 1 | Reported cancel of previous instruction |
| err_exc_code | output | 1 | Reserved exception type seen |
| err_mode | output | 1 | Thumb and bytecode both set |
| exc_lost | output | 1 | Held exception lost to automatic shutoff |

## Verification
A wrong held-exception or trace-started state does not show up when it goes wrong. It surfaces only at the next qualified instruction, as a missing, extra or mistyped `ev_exc`, or at the next automatic shutoff as a wrong `exc_lost` pulse. That can be many idle cycles after the fault. Qualification or size errors show up in the very next cycle on the event fields or on `bp_addr`. The reference model is therefore compared on every cycle, and the stimulus deliberately spaces exceptions, instructions and shutoffs apart.

// File: rtl/itq_pkg.sv
`timescale 1ns/1ps
package itq_pkg;

  typedef enum logic [2:0] {
    EXK_OTHER = 3'b000,
    EXK_IRQ   = 3'b001,
    EXK_BCODE = 3'b100,
    EXK_FIQ   = 3'b101,
    EXK_PDABT = 3'b110
  } exk_e;

  typedef struct packed {
    logic       kill;
    logic       dabt;
    logic       cancel;
    logic [2:0] kind;
  } exc_t;

  typedef struct packed {
    logic vld;
    logic inst;
    logic phan;
    logic thumb;
    logic bcode;
    logic icc;
    logic pcc;
    logic ind;
    logic ctx;
    logic data;
    logic bounce;
    logic exc;
    exc_t ex;
  } flags_t;

  // bytes occupied by one instruction in the current state
  function automatic logic [2:0] insn_size(input logic thumb, input logic bcode);
    if (bcode && !thumb)      return 3'd1;
    else if (thumb && !bcode) return 3'd2;
    else                      return 3'd4;
  endfunction

  function automatic logic [63:0] phantom_addr(input logic [63:0] addr, input logic [2:0] sz);
    return addr - {61'd0, sz};
  endfunction

  function automatic logic kind_legal(input logic [2:0] k);
    case (k)
      EXK_OTHER, EXK_IRQ, EXK_BCODE, EXK_FIQ, EXK_PDABT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/itq_decode.sv
`timescale 1ns/1ps
module itq_decode
  import itq_pkg::*;
(
  input  logic [17:0] ctl,
  output flags_t      fl,
  output logic        mode_both
);
  // layered qualification: each flag counts only when its parent does
  always_comb begin
    fl.vld       = ctl[0];
    fl.inst      = fl.vld  & ctl[1];
    fl.phan      = fl.vld  & ctl[2];
    fl.thumb     = fl.vld  & ctl[3];
    fl.bcode     = fl.vld  & ctl[4];
    fl.icc       = fl.inst & ctl[5];
    fl.pcc       = fl.phan & ctl[6];
    fl.ind       = fl.inst & ctl[7];
    fl.ctx       = fl.inst & ctl[8];
    fl.data      = fl.inst & ctl[9];
    fl.bounce    = fl.data & ctl[10];
    fl.exc       = fl.vld  & ctl[11];
    fl.ex.kind   = fl.exc ? ctl[14:12] : 3'b000;
    fl.ex.cancel = fl.exc & ctl[15];
    fl.ex.dabt   = fl.exc & ctl[16];
    fl.ex.kill   = fl.exc & ctl[17];
    mode_both    = fl.thumb & fl.bcode;
  end

  always_comb begin
    a_r4_bounce_parent : assert (!fl.bounce || (fl.data && fl.inst && fl.vld));
  end
endmodule

// File: rtl/itq_exc_track.sv
`timescale 1ns/1ps
module itq_exc_track
  import itq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic auto_off,
  input  logic inst,
  input  logic exc,
  input  exc_t exc_now,
  output logic rep_fire,
  output exc_t rep_info,
  output logic lost_fire
);
  logic started_q, pend_q;
  exc_t held_q;

  // named internal events
  logic cap_now;
  assign cap_now   = active & exc;
  assign rep_fire  = active & inst & started_q & (pend_q | exc);
  assign rep_info  = exc ? exc_now : held_q;
  assign lost_fire = pend_q & auto_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pend_q    <= 1'b0;
      held_q    <= '0;
    end else if (!active) begin
      started_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (cap_now) held_q <= exc_now;
      if (rep_fire)                   pend_q <= 1'b0;
      else if (cap_now && started_q)  pend_q <= 1'b1;
      if (inst) started_q <= 1'b1;
    end
  end

  a_r10_pend_needs_start : assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> started_q);
  a_r9_held_stable : assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cap_now) |=> $stable(held_q));
  a_r11_lost_drops : assert property (@(posedge clk) disable iff (!rst_n)
    lost_fire |=> !pend_q);
endmodule

// File: rtl/itrace_qual.sv
`timescale 1ns/1ps
module itrace_qual
  import itq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [17:0]   ctl_in,
  input  logic [AW-1:0] iaddr,
  input  logic          trace_en,
  input  logic          dbg_halt,
  input  logic          prohib_region,
  output logic          ev_valid,
  output logic          ev_inst,
  output logic          ev_phantom,
  output logic          ev_thumb,
  output logic          ev_bcode,
  output logic          ev_inst_ccfail,
  output logic          ev_phan_ccfail,
  output logic          ev_indirect,
  output logic          ev_ctxid,
  output logic          ev_data,
  output logic          ev_bounce,
  output logic [AW-1:0] bp_addr,
  output logic          ev_exc,
  output logic [2:0]    ev_exc_kind,
  output logic          ev_exc_kill,
  output logic          ev_exc_dabt,
  output logic          ev_exc_cancel,
  output logic          err_exc_code,
  output logic          err_mode,
  output logic          exc_lost
);
  localparam int WAW = 64;

  flags_t  fl;
  logic    mode_both;
  logic    auto_off, active;
  logic    rep_fire, lost_fire;
  exc_t    rep_info;
  logic [2:0]    cur_size;
  logic [AW-1:0] bp_next;

  assign auto_off = dbg_halt | prohib_region;
  assign active   = trace_en & ~auto_off;
  assign cur_size = insn_size(fl.thumb, fl.bcode);
  assign bp_next  = AW'(phantom_addr(WAW'(iaddr), cur_size));

  itq_decode u_dec (
    .ctl       (ctl_in),
    .fl        (fl),
    .mode_both (mode_both)
  );

  itq_exc_track u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .auto_off  (auto_off),
    .inst      (fl.inst),
    .exc       (fl.exc),
    .exc_now   (fl.ex),
    .rep_fire  (rep_fire),
    .rep_info  (rep_info),
    .lost_fire (lost_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0; ev_inst <= 1'b0; ev_phantom <= 1'b0;
      ev_thumb <= 1'b0; ev_bcode <= 1'b0;
      ev_inst_ccfail <= 1'b0; ev_phan_ccfail <= 1'b0;
      ev_indirect <= 1'b0; ev_ctxid <= 1'b0; ev_data <= 1'b0; ev_bounce <= 1'b0;
      bp_addr <= '0;
      ev_exc <= 1'b0; ev_exc_kind <= 3'b000;
      ev_exc_kill <= 1'b0; ev_exc_dabt <= 1'b0; ev_exc_cancel <= 1'b0;
      err_exc_code <= 1'b0; err_mode <= 1'b0; exc_lost <= 1'b0;
    end else begin
      ev_valid       <= active & fl.vld;
      ev_inst        <= active & fl.inst;
      ev_phantom     <= active & fl.phan;
      ev_thumb       <= active & fl.thumb;
      ev_bcode       <= active & fl.bcode;
      ev_inst_ccfail <= active & fl.icc;
      ev_phan_ccfail <= active & fl.pcc;
      ev_indirect    <= active & fl.ind;
      ev_ctxid       <= active & fl.ctx;
      ev_data        <= active & fl.data;
      ev_bounce      <= active & fl.bounce;
      bp_addr        <= (active & fl.phan) ? bp_next : '0;
      ev_exc         <= rep_fire;
      ev_exc_kind    <= rep_fire ? rep_info.kind : 3'b000;
      ev_exc_kill    <= rep_fire & rep_info.kill;
      ev_exc_dabt    <= rep_fire & rep_info.dabt;
      ev_exc_cancel  <= rep_fire & rep_info.cancel;
      err_exc_code   <= active & fl.exc & ~kind_legal(fl.ex.kind);
      err_mode       <= active & mode_both;
      exc_lost       <= lost_fire;
    end
  end

  a_r1_quiet_when_invalid : assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_in[0] |=> (!ev_valid && !ev_inst && !ev_phantom && !ev_exc && bp_addr == '0));
  a_r3_ccfail_parent : assert property (@(posedge clk) disable iff (!rst_n)
    ev_inst_ccfail |-> ev_inst);
  a_r4_bounce_data : assert property (@(posedge clk) disable iff (!rst_n)
    ev_bounce |-> ev_data);
  a_r8_mode_err : assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |-> (ev_thumb && ev_bcode));
  a_r11_lost_not_reported : assert property (@(posedge clk) disable iff (!rst_n)
    exc_lost |-> !ev_exc);
  a_r9_report_on_inst : assert property (@(posedge clk) disable iff (!rst_n)
    ev_exc |-> ev_inst);
endmodule

// File: tb/test_itrace_qual.sv
`timescale 1ns/1ps
module test_itrace_qual;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [17:0]   ctl_in = '0;
  logic [AW-1:0] iaddr = '0;
  logic          trace_en = 1'b0, dbg_halt = 1'b0, prohib_region = 1'b0;
  logic ev_valid, ev_inst, ev_phantom, ev_thumb, ev_bcode, ev_inst_ccfail, ev_phan_ccfail;
  logic ev_indirect, ev_ctxid, ev_data, ev_bounce, ev_exc, ev_exc_kill, ev_exc_dabt, ev_exc_cancel;
  logic err_exc_code, err_mode, exc_lost;
  logic [2:0]    ev_exc_kind;
  logic [AW-1:0] bp_addr;

  always #4 clk = ~clk;

  itrace_qual #(.AW(AW)) i_itrace_qual (.*);

  int total = 0, bad = 0;

  // expected outputs for the next comparison
  bit [10:0] x_ev;   // valid,inst,phan,thumb,bcode,icc,pcc,ind,ctx,data,bounce
  bit [31:0] x_bp;
  bit        x_exc, x_kill, x_dabt, x_cancel, x_cerr, x_merr, x_lost;
  bit [2:0]  x_kind;
  // model state
  bit        m_started, m_pend, h_kill, h_dabt, h_cancel;
  bit [2:0]  h_kind;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1/R2 state flags", {ev_valid, ev_inst, ev_phantom, ev_thumb, ev_bcode},
        {x_ev[10], x_ev[9], x_ev[8], x_ev[7], x_ev[6]});
    chk("R3 qualified flags", {ev_inst_ccfail, ev_phan_ccfail, ev_indirect, ev_ctxid, ev_data},
        {x_ev[5], x_ev[4], x_ev[3], x_ev[2], x_ev[1]});
    chk("R4 bounce", ev_bounce, x_ev[0]);
    chk("R7 phantom address", bp_addr, x_bp);
    chk("R9/R10 exception report", ev_exc, x_exc);
    chk("R5 exception fields", {ev_exc_kind, ev_exc_kill, ev_exc_dabt, ev_exc_cancel},
        {x_kind, x_kill, x_dabt, x_cancel});
    chk("R6 reserved code", err_exc_code, x_cerr);
    chk("R8 mode error", err_mode, x_merr);
    chk("R11 lost exception", exc_lost, x_lost);
  endtask

  // behavioural reference for one clock edge
  task automatic model();
    bit act, v, iv, pv, th, bc, ex, fire;
    int sz;
    bit [2:0] k;
    act = trace_en && !(dbg_halt || prohib_region);
    v = ctl_in[0]; iv = v && ctl_in[1]; pv = v && ctl_in[2];
    th = v && ctl_in[3]; bc = v && ctl_in[4];
    ex = v && ctl_in[11]; k = ctl_in[14:12];
    if (!rst_n) begin
      x_ev = '0; x_bp = 0; {x_exc, x_kill, x_dabt, x_cancel, x_cerr, x_merr, x_lost} = '0;
      x_kind = 0; m_started = 0; m_pend = 0; {h_kill, h_dabt, h_cancel, h_kind} = '0;
      return;
    end
    x_ev = '0;
    if (act) begin
      x_ev[10] = v; x_ev[9] = iv; x_ev[8] = pv; x_ev[7] = th; x_ev[6] = bc;
      x_ev[5] = iv && ctl_in[5]; x_ev[4] = pv && ctl_in[6];
      x_ev[3] = iv && ctl_in[7]; x_ev[2] = iv && ctl_in[8];
      x_ev[1] = iv && ctl_in[9]; x_ev[0] = iv && ctl_in[9] && ctl_in[10];
    end
    sz = (bc && !th) ? 1 : ((th && !bc) ? 2 : 4);
    x_bp = (act && pv) ? iaddr - sz : 0;
    x_cerr = act && ex && (k == 2 || k == 3 || k == 7);
    x_merr = act && th && bc;
    x_lost = m_pend && (dbg_halt || prohib_region);
    fire = act && iv && m_started && (m_pend || ex);
    x_exc = fire; x_kind = 0; x_kill = 0; x_dabt = 0; x_cancel = 0;
    if (fire) begin
      if (ex) begin
        x_kind = k; x_kill = ctl_in[17]; x_dabt = ctl_in[16]; x_cancel = ctl_in[15];
      end else begin
        x_kind = h_kind; x_kill = h_kill; x_dabt = h_dabt; x_cancel = h_cancel;
      end
    end
    if (!act) begin
      m_started = 0; m_pend = 0;
    end else begin
      if (ex) begin
        h_kind = k; h_kill = ctl_in[17]; h_dabt = ctl_in[16]; h_cancel = ctl_in[15];
      end
      if (fire) m_pend = 0;
      else if (ex && m_started) m_pend = 1;
      if (iv) m_started = 1;
    end
  endtask

  task automatic tick(input bit [17:0] c, input bit [31:0] a,
                      input bit en = 1, input bit dg = 0, input bit pr = 0);
    @(negedge clk);
    compare_all();
    ctl_in = c; iaddr = a; trace_en = en; dbg_halt = dg; prohib_region = pr;
    model();
  endtask

  localparam bit [17:0] V = 18'h1, I = 18'h2, P = 18'h4, T = 18'h8, J = 18'h10;
  localparam bit [17:0] ICC = 18'h20, PCC = 18'h40, IND = 18'h80, CTX = 18'h100;
  localparam bit [17:0] DAT = 18'h200, BNC = 18'h400, EXC = 18'h800;
  localparam bit [17:0] CAN = 18'h8000, DAB = 18'h10000, KIL = 18'h20000;

  function automatic bit [17:0] exk(input bit [2:0] k);
    return EXC | (18'(k) << 12);
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model();
    // R12: reset state
    repeat (3) tick(V | I | P | EXC, 32'h100, 1);
    @(negedge clk);
    chk("R12 reset outputs", {ev_valid, ev_inst, ev_exc, exc_lost, bp_addr}, 0);
    rst_n = 1'b1; model();
    tick(0, 0);
    // R1: invalid / powered down and trace off
    tick(I | P | T | DAT | EXC, 32'h200);
    tick(V | I | P | ICC, 32'h204, 0);
    tick(V | I | P, 32'h208, 1, 1);
    // R2/R3/R4/R7 modes and phantoms
    tick(V | I | P | ICC | PCC | IND, 32'h1000);
    tick(V | P | T | PCC, 32'h2002);
    tick(V | I | P | J | CTX, 32'h3001);
    tick(V | I | P | T | J, 32'h4000);          // R8 both state bits
    tick(V | P | ICC | IND | CTX | DAT | BNC, 32'h10);   // R3 without inst
    tick(V | I | BNC, 32'h20);                  // R4 bounce without data
    tick(V | I | DAT | BNC, 32'h24);
    tick(V | I | ICC | IND | CTX | DAT, 32'h28);
    tick(V | P, 32'h0);                         // R7 wrap
    // R10: restart trace, exception before first instruction discarded
    tick(0, 0, 0);
    tick(V | exk(3'b001), 32'h18);
    tick(0, 0);
    tick(V | I, 32'h500);                       // first instruction, no report
    tick(V | I, 32'h504);
    // R9: held IRQ reported after idle cycles
    tick(V | exk(3'b001) | KIL, 32'h18);
    tick(0, 0); tick(V | P, 32'h40);
    tick(V | I, 32'h18);
    // R9: newer exception replaces held one
    tick(V | exk(3'b101) | DAB, 32'h1c);
    tick(V | exk(3'b110) | CAN | KIL, 32'h10);
    tick(V | I, 32'h10);
    tick(V | I | exk(3'b100) | DAB, 32'h20);    // same-cycle report
    // R10: first instruction after restart sits at vector
    tick(0, 0, 0);
    tick(V | I | exk(3'b101), 32'h1c);
    tick(V | I, 32'h20);
    // R6 reserved codes
    tick(V | exk(3'b010), 0); tick(V | exk(3'b011), 0); tick(V | exk(3'b111), 0);
    tick(V | exk(3'b000), 0);
    tick(V | I, 32'h8);
    // R11: lost on debug entry, on prohibited region, not on trace_en drop
    tick(V | exk(3'b001), 0); tick(0, 0, 1, 1); tick(0, 0);
    tick(V | I, 32'h30); tick(V | exk(3'b101), 0); tick(0, 0, 1, 0, 1); tick(0, 0);
    tick(V | I, 32'h34); tick(V | exk(3'b110), 0); tick(0, 0, 0); tick(0, 0);
    tick(V | I, 32'h38); tick(V | I, 32'h3c);
    // R12: reset clears held exception and started state
    tick(V | exk(3'b001), 0);
    @(negedge clk); compare_all(); rst_n = 1'b0; model();
    @(negedge clk); compare_all(); rst_n = 1'b1; model();
    tick(V | I, 32'h18); tick(V | I, 32'h1c);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit [17:0] c;
      bit en, dg, pr;
      c = 18'($urandom);
      c[0] = ($urandom_range(0, 9) != 0);
      c[11] = ($urandom_range(0, 5) == 0);
      c[1] = ($urandom_range(0, 2) == 0);
      en = ($urandom_range(0, 40) != 0);
      dg = ($urandom_range(0, 60) == 0);
      pr = ($urandom_range(0, 60) == 0);
      tick(c, $urandom, en, dg, pr);
    end
    tick(0, 0);
    @(negedge clk); compare_all();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule